// File: doc/BRIEF.md
# Configuration Stream Header Ratio Selector

This block sits beside the 32-bit word stream that feeds a parallel configuration port. It reads the stream without altering it and looks at two fixed words in the image header. Word 69 carries the encryption status and word 229 carries the compression status. From these two bits and the port width mode it chooses a clock-to-data ratio code. A downstream clock generator uses that code, together with a width-select bit, to set how many configuration clocks each data word gets.

A session begins with a one-cycle start pulse. The pulse carries the declared stream length in words and the width mode. A declared length under 230 words cannot hold both header words. In that case the block raises an error and produces no ratio. Otherwise the block counts accepted beats. It captures the encryption bits when word 69 arrives. When word 229 arrives it issues the ratio code with a one-cycle valid strobe. All later words are ignored until the next start.

The stream port is valid/ready, and the block only observes it. Ready stays high at all times, so the block never applies back-pressure and never stalls the payload transfer. A word counts as a beat only in a cycle where valid and ready are both high.

Top module: `cfg_ratio_sel`

## Requirements
- R1: Word index 69 (counting from 0 over accepted beats) marks the image encrypted when its bits [3:2] are not both zero. No other word affects the encryption decision.
- R2: Word index 229 marks the image compressed when its bit 1 is 0. No other word affects the compression decision.
- R3: A start pulse whose declared length is below 230 sets `err_o` on the next cycle. While `err_o` is high, `ratio_vld_o` stays low for the rest of that session.
- R4: An image that is neither encrypted nor compressed gets ratio code 0 (x1) in both width modes.
- R5: With `wide_i`=0 (16-bit mode), a compressed image gets code 2 (x4) whether or not it is encrypted, and an image that is only encrypted gets code 1 (x2).
- R6: With `wide_i`=1 (32-bit mode), an encrypted or compressed image gets the 16-bit code plus one. This gives code 3 (x8) when compressed and code 2 (x4) when only encrypted.
- R7: The ratio code encoding is 0=x1, 1=x2, 2=x4, 3=x8.
- R8: Only cycles with `s_valid_i` high advance the word index. Data presented while valid is low is ignored. Words that arrive after word 229 change nothing.
- R9: `ratio_vld_o` pulses high for exactly one cycle, in the cycle right after the clock edge that accepts word 229. `ratio_code_o` is valid in that cycle and holds its value until the next start.
- R10: A start pulse clears the word index, the captured encryption bit, `err_o`, `ratio_vld_o` and `ratio_code_o`.
- R11: `wide_sel_o` takes the value of `wide_i` at each start pulse and holds it until the next start. It is 0 after reset.
- R12: `s_ready_o` is high in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens a new session |
| len_i | input | LEN_W (16) | Declared stream length in words, sampled with the start pulse |
| wide_i | input | 1 | Width mode sampled with the start pulse: 1 = 32-bit, 0 = 16-bit |
| s_valid_i | input | 1 | A stream word is present |
| s_data_i | input | DATA_W (32) | Stream word |
| s_ready_o | output | 1 | Always high; the block never back-pressures the stream |
| ratio_code_o | output | 2 | Clock-to-data ratio code (0=x1, 1=x2, 2=x4, 3=x8) |
| ratio_vld_o | output | 1 | One-cycle strobe that marks `ratio_code_o` as decided |
| wide_sel_o | output | 1 | Latched width select for the clock generator |
| err_o | output | 1 | Declared length too short to contain the header words |

## Verification
The bench fills every header word other than 69 and 229 with a pattern that would flip both decisions. An off-by-one index, or counting beats while valid is low, would therefore show up as a wrong code. It runs all eight combinations of width, encryption and compression, and checks that 16-bit mode never produces x8 and that 32-bit mode doubles only non-x1 results. It also tests a length of exactly 229 against exactly 230, restarts a session mid-stream after an encrypted word 69, and sends words after word 229. A design that kept stale state, fired the strobe early or more than once, or reacted to late words would fail these checks.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DONE    = 2'd2,
    ST_FAULT   = 2'd3
  } hdr_state_e;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

endpackage

// File: rtl/hdr_beat_counter.sv
module hdr_beat_counter #(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int CNT_W   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic beat_i,
  output logic hit_enc_o,
  output logic hit_cmp_o
);

  localparam logic [CNT_W-1:0] ENC_AT = CNT_W'(ENC_IDX);
  localparam logic [CNT_W-1:0] CMP_AT = CNT_W'(CMP_IDX);

  logic [CNT_W-1:0] idx_q;

  // Index of the word currently on the stream; it moves only on accepted beats.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (beat_i && idx_q != CMP_AT) idx_q <= idx_q + 1'b1;
  end

  assign hit_enc_o = beat_i && (idx_q == ENC_AT);
  assign hit_cmp_o = beat_i && (idx_q == CMP_AT);

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              enc_hit_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              enc_o,
  output logic              cmp_now_o
);

  logic enc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enc_q <= 1'b0;
    else if (clr_i)     enc_q <= 1'b0;
    else if (enc_hit_i) enc_q <= |data_i[3:2];
  end

  assign enc_o     = enc_q;
  // Compression flag is active low in the header; only meaningful on the word 229 beat.
  assign cmp_now_o = ~data_i[1];

endmodule

// File: rtl/ratio_encode.sv
module ratio_encode
  import cfghdr_pkg::*;
(
  input  logic       enc_i,
  input  logic       cmp_i,
  input  logic       wide_i,
  output logic [1:0] code_o
);

  logic [1:0] narrow;

  always_comb begin
    if (cmp_i)      narrow = RATIO_X4;
    else if (enc_i) narrow = RATIO_X2;
    else            narrow = RATIO_X1;
    // One encoding step doubles the ratio; x1 is never doubled.
    if (wide_i && (enc_i || cmp_i)) code_o = narrow + 2'd1;
    else                            code_o = narrow;
  end

endmodule

// File: rtl/cfg_ratio_sel.sv
module cfg_ratio_sel
  import cfghdr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int MIN_LEN = CMP_IDX + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wide_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic [1:0]        ratio_code_o,
  output logic              ratio_vld_o,
  output logic              wide_sel_o,
  output logic              err_o
);

  localparam int CNT_W = $clog2(CMP_IDX + 2);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);

  hdr_state_e state_q;
  logic       beat, hit_enc, hit_cmp, enc_flag, cmp_now, short_len;
  logic [1:0] code_next;

  assign s_ready_o = 1'b1;
  assign short_len = len_i < LEN_MIN;
  assign beat      = s_valid_i && s_ready_o && !start_i && (state_q == ST_COLLECT);

  hdr_beat_counter #(
    .ENC_IDX (ENC_IDX),
    .CMP_IDX (CMP_IDX),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (start_i),
    .beat_i    (beat),
    .hit_enc_o (hit_enc),
    .hit_cmp_o (hit_cmp)
  );

  hdr_flag_capture #(
    .DATA_W (DATA_W)
  ) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (start_i),
    .enc_hit_i (hit_enc),
    .data_i    (s_data_i),
    .enc_o     (enc_flag),
    .cmp_now_o (cmp_now)
  );

  ratio_encode u_enc (
    .enc_i  (enc_flag),
    .cmp_i  (cmp_now),
    .wide_i (wide_sel_o),
    .code_o (code_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      ratio_code_o <= RATIO_X1;
      ratio_vld_o  <= 1'b0;
      wide_sel_o   <= 1'b0;
      err_o        <= 1'b0;
    end else if (start_i) begin
      state_q      <= short_len ? ST_FAULT : ST_COLLECT;
      err_o        <= short_len;
      wide_sel_o   <= wide_i;
      ratio_code_o <= RATIO_X1;
      ratio_vld_o  <= 1'b0;
    end else begin
      ratio_vld_o <= 1'b0;
      if (hit_cmp) begin
        ratio_code_o <= code_next;
        ratio_vld_o  <= 1'b1;
        state_q      <= ST_DONE;
      end
    end
  end

endmodule

// File: rtl/cfg_ratio_sel_chk.sv
module cfg_ratio_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] ratio_code_o,
  input logic       ratio_vld_o,
  input logic       wide_sel_o,
  input logic       err_o
);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_vld_o |=> !ratio_vld_o);

  a_r9_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_vld_o && !start_i) |=> $stable(ratio_code_o));

  a_r3_err_blocks_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !ratio_vld_o);

  a_r5_narrow_no_x8: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_vld_o && !wide_sel_o) |-> (ratio_code_o != 2'd3));

  a_r6_wide_no_x2: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_vld_o && wide_sel_o) |-> (ratio_code_o != 2'd1));

  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!ratio_vld_o && ratio_code_o == 2'd0));

  a_r11_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(wide_sel_o));

endmodule

bind cfg_ratio_sel cfg_ratio_sel_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ratio_code_o (ratio_code_o),
  .ratio_vld_o  (ratio_vld_o),
  .wide_sel_o   (wide_sel_o),
  .err_o        (err_o)
);

// File: tb/cfg_ratio_sel_tb.sv
module cfg_ratio_sel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] len_i = '0;
  logic        wide_i = 1'b0;
  logic        s_valid_i = 1'b0;
  logic [31:0] s_data_i = '0;
  logic        s_ready_o, ratio_vld_o, wide_sel_o, err_o;
  logic [1:0]  ratio_code_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #10 clk = ~clk;

  cfg_ratio_sel u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .wide_i(wide_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .ratio_code_o(ratio_code_o), .ratio_vld_o(ratio_vld_o),
    .wide_sel_o(wide_sel_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input bit wide, input bit enc, input bit comp);
    if (!enc && !comp) return 2'd0;          // R4
    if (!wide)         return comp ? 2'd2 : 2'd1; // R5
    return comp ? 2'd3 : 2'd2;               // R6
  endfunction

  // Every word other than 69 and 229 carries the opposite of the wanted flags.
  function automatic logic [31:0] word_at(input int i, input bit enc, input bit comp, input bit alt);
    if (i == 69)  return enc ? (alt ? 32'h0000_0008 : 32'h0000_0004) : 32'hFFFF_FFF3;
    if (i == 229) return comp ? 32'hFFFF_FFFD : 32'h0000_0002;
    return {28'hA5A5A5A, enc ? 2'b00 : 2'b11, comp, 1'b0};
  endfunction

  task automatic do_start(input int len, input bit wide);
    @(negedge clk);
    start_i = 1'b1; len_i = 16'(len); wide_i = wide; s_valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_image(input int len, input bit wide, input bit enc, input bit comp,
                           input bit gaps, input string tag);
    bit early = 1'b0;
    logic [1:0] want;
    want = exp_code(wide, enc, comp);
    do_start(len, wide);
    check(err_o == 1'b0, {"R10 err clear ", tag}, err_o, 0);
    check(wide_sel_o == wide, {"R11 wide_sel ", tag}, wide_sel_o, wide);
    for (int i = 0; i < 230; i++) begin
      if (gaps && (i % 3 == 1)) begin
        s_valid_i = 1'b0; s_data_i = word_at(i + 1, !enc, !comp, 1'b0);
        @(negedge clk);
        if (ratio_vld_o) early = 1'b1;
      end
      s_valid_i = 1'b1; s_data_i = word_at(i, enc, comp, gaps);
      @(negedge clk);
      if (i < 229 && ratio_vld_o) early = 1'b1;
    end
    check(!early, {"R9 no early strobe ", tag}, early, 0);
    check(ratio_vld_o == 1'b1, {"R9 strobe after word 229 ", tag}, ratio_vld_o, 1);
    check(ratio_code_o == want, {"R1 R2 R7 code ", tag}, ratio_code_o, want);
    // Late words with flipped flags must change nothing.
    for (int k = 0; k < 4; k++) begin
      s_valid_i = 1'b1; s_data_i = word_at(229, !enc, !comp, 1'b0);
      @(negedge clk);
      check(ratio_vld_o == 1'b0, {"R9 R8 single pulse ", tag}, ratio_vld_o, 0);
    end
    check(ratio_code_o == want, {"R8 code held after late words ", tag}, ratio_code_o, want);
    s_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check(ratio_vld_o == 1'b0, "R9 reset vld", ratio_vld_o, 0);
    check(ratio_code_o == 2'd0, "R10 reset code", ratio_code_o, 0);
    check(err_o == 1'b0, "R3 reset err", err_o, 0);
    check(wide_sel_o == 1'b0, "R11 reset wide_sel", wide_sel_o, 0);
    check(s_ready_o == 1'b1, "R12 ready in reset", s_ready_o, 1);
  endtask

  task automatic t_short_len;
    bit seen = 1'b0;
    do_start(229, 1'b1);
    check(err_o == 1'b1, "R3 short length error", err_o, 1);
    for (int i = 0; i < 240; i++) begin
      s_valid_i = 1'b1; s_data_i = word_at(i, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      if (ratio_vld_o) seen = 1'b1;
      if (!s_ready_o)  seen = 1'b1;
    end
    s_valid_i = 1'b0;
    check(!seen, "R3 R12 no ratio on short stream", seen, 0);
    check(err_o == 1'b1, "R3 error held", err_o, 1);
  endtask

  task automatic t_restart;
    do_start(400, 1'b0);
    for (int i = 0; i < 100; i++) begin
      s_valid_i = 1'b1; s_data_i = word_at(i, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
    end
    s_valid_i = 1'b0;
    run_image(230, 1'b0, 1'b0, 1'b0, 1'b0, "restart R10");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_image(230, 1'b0, 1'b0, 1'b0, 1'b0, "n plain R4");
    run_image(500, 1'b0, 1'b1, 1'b0, 1'b0, "n enc R5");
    run_image(230, 1'b0, 1'b0, 1'b1, 1'b1, "n comp R5");
    run_image(300, 1'b0, 1'b1, 1'b1, 1'b0, "n enc comp R5");
    run_image(230, 1'b1, 1'b0, 1'b0, 1'b1, "w plain R4");
    run_image(230, 1'b1, 1'b1, 1'b0, 1'b1, "w enc R6 R8 gaps");
    run_image(999, 1'b1, 1'b0, 1'b1, 1'b0, "w comp R6");
    run_image(230, 1'b1, 1'b1, 1'b1, 1'b0, "w enc comp R6");
    t_short_len();
    run_image(230, 1'b1, 1'b0, 1'b1, 1'b0, "after error R10");
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule